// File: doc/BRIEF.md
# Prediction-Guarded Filter Output Corrector

This block sits behind a filter datapath that is allowed to be unreliable, for instance because its supply has been lowered past the point where every path meets timing. Each valid cycle it receives the datapath's result, which may carry a large arithmetic error. It also forms its own estimate of that result from the outputs it has already released. If the datapath result lies further from the estimate than a programmable threshold, the estimate is released in its place. Otherwise the datapath result passes through unchanged.

The estimate comes from a short linear predictor, two taps by default, over the history of corrected outputs. Its coefficients are inputs in signed Q1.14 format. A difference mode instead takes the most recent corrected output as the estimate, which suits strongly correlated signals. Only corrected values enter the history, so one bad result cannot spoil the estimates that follow it. A flag marks each substituted sample, and a counter records how many substitutions have been made.

Top module: `ant_guard`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_y, err_flag and sub_count are all zero, and every history entry is zero.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. out_y and err_flag are registered and refer to that sample.
- R3: When a sample is not substituted, out_y equals main_y of that sample exactly and err_flag is low.
- R4: After warm-up, a sample is substituted when |main_y - estimate| > thresh (strictly greater; thresh is unsigned 16 bits). out_y then equals the estimate and err_flag is high for that one output cycle. A difference equal to thresh passes through.
- R5: With mode_diff low, the estimate is sat16(floor(sum over k of h_k * c_k / 2^14)). c_k is the corrected output k samples back, with k = 1 the newest. h_k is the signed 16-bit field coef[16k-1:16(k-1)].
- R6: With mode_diff high, the estimate is the previous corrected output and the coefficients are ignored.
- R7: The history is fed with the released (corrected) output, never with the raw main_y.
- R8: For the first NTAPS valid samples after reset no substitution is made, whatever the difference. err_flag stays low and sub_count does not move.
- R9: sub_count increases by one on each substituted sample, wrapping modulo 2^16.
- R10: Cycles with in_valid low leave the history unchanged, whatever main_y carries.
- R11: The predictor sum saturates to the range -32768..32767 before it is compared and released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | main_y carries a new sample this cycle |
| main_y | input | 16 | Possibly erroneous datapath result, two's complement |
| mode_diff | input | 1 | 1 selects difference mode, 0 the linear predictor |
| thresh | input | 16 | Unsigned decision threshold |
| coef | input | 16*NTAPS | Predictor coefficients in Q1.14, tap 1 in the low field |
| out_valid | output | 1 | Corrected sample valid |
| out_y | output | 16 | Corrected sample |
| err_flag | output | 1 | This output sample was substituted |
| sub_count | output | 16 | Running count of substitutions |

## Verification
The bench drives main_y to exactly thresh and to thresh+1 away from the estimate. A design that compares with >= instead of > substitutes the first of these samples, and one that never substitutes lets the second one through. It injects large errors during the warm-up samples, where a design that decides too early would substitute against an all-zero history. It injects two errors in a row in difference mode, where a design that stores the raw main_y would pass the second error through unchanged. Finally, it loads near-full-scale history with large coefficients, so an estimate that is not saturated wraps to the wrong sign, and it toggles main_y on idle cycles, which would shift a design that ignores in_valid.

// File: rtl/ant_pkg.sv
`timescale 1ns/1ps
// Package ant_pkg
// Shared widths for the prediction-guarded corrector.
// Assumes two's complement samples and Q1.14 coefficients.
package ant_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int FRAC_BITS = 14;
    localparam int COUNT_W   = 16;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/ant_predictor.sv
`timescale 1ns/1ps
// Module ant_predictor
// Keeps the history of corrected outputs and forms the estimate,
// either as a saturated Q1.14 dot product or, in difference mode,
// as the newest history entry.
// Assumes shift_en is high only for samples that are actually released.
module ant_predictor
    import ant_pkg::*;
#(
    parameter int NTAPS = 2,
    parameter int DW    = SAMPLE_W,
    parameter int CW    = COEF_W,
    parameter int FRAC  = FRAC_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic signed [DW-1:0]   shift_val,
    input  logic                   mode_diff,
    input  logic [NTAPS*CW-1:0]    coef,
    output logic signed [DW-1:0]   est
);
    localparam int PW    = DW + CW;
    localparam int ACC_W = PW + $clog2(NTAPS) + 1;
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((2 ** (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = ~SMAX;

    logic signed [DW-1:0]    hist [NTAPS];
    logic signed [PW-1:0]    prod [NTAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    logic signed [DW-1:0]    est_mac;

    // History shift: newest corrected output enters slot 0 on each release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) hist[k] <= '0;
        end else if (shift_en) begin
            hist[0] <= shift_val;
            for (int k = 1; k < NTAPS; k++) hist[k] <= hist[k-1];
        end
    end

    // One signed multiplier per tap.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        assign prod[k] = hist[k] * $signed(coef[k*CW +: CW]);
    end

    // Sum of tap products, sign extended to the accumulator width.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) begin
            acc = acc + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
        end
    end

    // Drop fractional bits (floor) and clamp to the sample range.
    always_comb begin
        scaled = acc >>> FRAC;
        if (scaled > SMAX)      est_mac = SMAX[DW-1:0];
        else if (scaled < SMIN) est_mac = SMIN[DW-1:0];
        else                    est_mac = scaled[DW-1:0];
    end

    // Estimate source: newest history entry in difference mode.
    always_comb begin
        est = mode_diff ? hist[0] : est_mac;
    end

    // R10: idle cycles never disturb the history
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(hist[0]) && $stable(hist[NTAPS-1])));
endmodule

// File: rtl/ant_decide.sv
`timescale 1ns/1ps
// Module ant_decide
// Compares the datapath result with the estimate and picks the value
// to release. Holds off any substitution until NTAPS valid samples
// have filled the history after reset.
// Assumes thresh is an unsigned magnitude.
module ant_decide
    import ant_pkg::*;
#(
    parameter int NTAPS = 2,
    parameter int DW    = SAMPLE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   main_y,
    input  logic signed [DW-1:0]   est,
    input  logic [DW-1:0]          thresh,
    output logic                   take_est,
    output logic signed [DW-1:0]   sel_y
);
    localparam int WCW = $clog2(NTAPS + 1);
    localparam logic [WCW-1:0] WARM_N = WCW'(NTAPS);

    logic [WCW-1:0]        warm_cnt;
    logic                  warm_done;
    logic signed [DW:0]    delta;
    logic [DW:0]           mag;
    logic                  too_far;

    // Warm-up counter: counts valid samples up to NTAPS, then holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                       warm_cnt <= '0;
        else if (in_valid && !warm_done)  warm_cnt <= warm_cnt + 1'b1;
    end

    // Distance test: one extra bit so the subtraction cannot wrap.
    always_comb begin
        warm_done = (warm_cnt == WARM_N);
        delta     = {main_y[DW-1], main_y} - {est[DW-1], est};
        mag       = delta[DW] ? DW'(0) - delta : delta;
        too_far   = mag > {1'b0, thresh};
    end

    // Output selection for this sample.
    always_comb begin
        take_est = in_valid && warm_done && too_far;
        sel_y    = take_est ? est : main_y;
    end

    // R8: nothing is substituted while the history is still filling
    p_warmup_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && warm_cnt < WARM_N) |-> (sel_y == main_y));
endmodule

// File: rtl/ant_guard.sv
`timescale 1ns/1ps
// Module ant_guard
// Top of the prediction-guarded corrector: joins predictor and decision
// logic, registers the released sample, its flag and the substitution
// count. One sample per cycle, one cycle of latency.
// Assumes coef holds NTAPS signed Q1.14 fields, tap 1 lowest.
module ant_guard
    import ant_pkg::*;
#(
    parameter int NTAPS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [SAMPLE_W-1:0]          main_y,
    input  logic                         mode_diff,
    input  logic [SAMPLE_W-1:0]          thresh,
    input  logic [NTAPS*COEF_W-1:0]      coef,
    output logic                         out_valid,
    output logic [SAMPLE_W-1:0]          out_y,
    output logic                         err_flag,
    output logic [COUNT_W-1:0]           sub_count
);
    sample_t est;
    sample_t sel_y;
    logic    take_est;

    ant_predictor #(.NTAPS(NTAPS)) i_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (in_valid),
        .shift_val (sel_y),
        .mode_diff (mode_diff),
        .coef      (coef),
        .est       (est)
    );

    ant_decide #(.NTAPS(NTAPS)) i_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .main_y   ($signed(main_y)),
        .est      (est),
        .thresh   (thresh),
        .take_est (take_est),
        .sel_y    (sel_y)
    );

    // Output register: released sample, valid and substitution flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            err_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            err_flag  <= take_est;
            if (in_valid) out_y <= sel_y;
        end
    end

    // Substitution counter, wraps modulo 2^COUNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)        sub_count <= '0;
        else if (take_est) sub_count <= sub_count + 1'b1;
    end

    // R2: one output per accepted sample, one cycle later
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    // R3: an unflagged output is the datapath value unchanged
    p_pass_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !err_flag) |-> (out_y == $past(main_y)));
    // R4: a flag only accompanies a released sample
    p_flag_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> out_valid);
    // R9: the counter moves by exactly the flag
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sub_count == COUNT_W'($past(sub_count) + {{(COUNT_W-1){1'b0}}, err_flag}));
endmodule

// File: tb/test_ant_guard.sv
`timescale 1ns/1ps
module test_ant_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] main_y = '0;
    logic        mode_diff = 1'b0;
    logic [15:0] thresh = '0;
    logic [31:0] coef = '0;
    logic        out_valid;
    logic [15:0] out_y;
    logic        err_flag;
    logic [15:0] sub_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference state built from the requirements
    int m_h0, m_h1, m_seen, m_cnt, m_c1, m_c2, m_thr;
    bit m_diff;

    ant_guard #(.NTAPS(2)) i_ant_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .main_y(main_y),
        .mode_diff(mode_diff), .thresh(thresh), .coef(coef),
        .out_valid(out_valid), .out_y(out_y), .err_flag(err_flag),
        .sub_count(sub_count)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_est();
        longint a;
        if (m_diff) return m_h0;
        a = longint'(m_c1) * m_h0 + longint'(m_c2) * m_h1;
        a = a >>> 14;
        if (a > 32767) return 32767;
        if (a < -32768) return -32768;
        return int'(a);
    endfunction

    task automatic set_cfg(input bit d, input int c1, input int c2, input int thr);
        m_diff = d; m_c1 = c1; m_c2 = c2; m_thr = thr;
        mode_diff = d; coef = {16'(c2), 16'(c1)}; thresh = 16'(thr);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_h0 = 0; m_h1 = 0; m_seen = 0; m_cnt = 0;
    endtask

    // One valid sample; called at a falling edge, returns at the next one.
    task automatic step(input int mv, input string tag);
        int e, d, expo;
        bit sub;
        e = m_est();
        d = mv - e;
        if (d < 0) d = -d;
        sub = (m_seen >= 2) && (d > m_thr);
        expo = sub ? e : mv;
        in_valid = 1'b1; main_y = 16'(mv);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (sub) m_cnt = (m_cnt + 1) % 65536;
        chk(out_valid === 1'b1, "R2 out_valid", int'(out_valid), 1);
        chk($signed(out_y) == expo, tag, int'($signed(out_y)), expo);
        chk(err_flag === sub, {tag, " flag R4"}, int'(err_flag), int'(sub));
        chk(int'(sub_count) == m_cnt, "R9 sub_count", int'(sub_count), m_cnt);
        m_h1 = m_h0; m_h0 = expo;
        if (m_seen < 2) m_seen++;
    endtask

    task automatic t_reset();
        set_cfg(0, 24576, -8192, 200);
        do_reset();
        chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_y === 16'h0, "R1 out_y", int'(out_y), 0);
        chk(err_flag === 1'b0, "R1 err_flag", int'(err_flag), 0);
        chk(sub_count === 16'h0, "R1 sub_count", int'(sub_count), 0);
        chk(m_est() == 0, "R1 history", 0, 0);
    endtask

    task automatic t_warmup();
        set_cfg(0, 24576, -8192, 10);
        do_reset();
        step(9000, "R8 warm-up sample 1");
        step(-9000, "R8 warm-up sample 2");
        chk(err_flag === 1'b0 && sub_count === 16'h0, "R8 no flag", int'(sub_count), 0);
    endtask

    task automatic t_ramp_inject();
        set_cfg(0, 24576, -8192, 200);
        do_reset();
        for (int k = 1; k <= 6; k++) step(100 * k, "R3 clean ramp");
        step(700 + 5000, "R4 injected error replaced");
        chk(($signed(out_y) - 700) <= 200 && ($signed(out_y) - 700) >= -200,
            "R4 residual bounded", int'($signed(out_y)) - 700, 0);
        step(800, "R5 predictor after substitution");
        // idle cycles with junk on main_y
        for (int k = 0; k < 3; k++) begin
            main_y = 16'(12345 * (k + 1));
            @(negedge clk);
            chk(out_valid === 1'b0, "R2 idle out_valid", int'(out_valid), 0);
        end
        step(900, "R10 history kept across idle");
        step(1000 - 6000, "R4 negative error replaced");
    endtask

    task automatic t_threshold_edge();
        int e;
        set_cfg(0, 16384, 0, 50);
        do_reset();
        step(400, "R3 warm");
        step(420, "R3 warm");
        e = m_est();
        step(e + 50, "R4 equal to threshold passes");
        e = m_est();
        step(e + 51, "R4 one above threshold substituted");
        chk(err_flag === 1'b1, "R4 edge flag", int'(err_flag), 1);
        e = m_est();
        step(e - 51, "R4 one below negative edge substituted");
        set_cfg(0, 12000, 5000, 50);
        step(300, "R5 new coefficients");
        step(m_est() + 30, "R5 estimate from coefficients");
    endtask

    task automatic t_diff_mode();
        set_cfg(1, 7, -7, 100);
        do_reset();
        step(1000, "R6 warm");
        step(1010, "R6 warm");
        step(1020, "R6 close sample passes");
        step(6020, "R6 error replaced by previous");
        chk($signed(out_y) == 1020, "R6 previous value", int'($signed(out_y)), 1020);
        step(6030, "R7 second error also replaced");
        chk($signed(out_y) == 1020, "R7 corrected history", int'($signed(out_y)), 1020);
        step(1050, "R6 recovery");
    endtask

    task automatic t_saturate();
        set_cfg(0, 30720, 30720, 100);
        do_reset();
        step(30000, "R11 warm");
        step(30000, "R11 warm");
        step(0, "R11 positive clamp");
        chk($signed(out_y) == 32767, "R11 clamp high", int'($signed(out_y)), 32767);
        set_cfg(0, 30720, 30720, 100);
        do_reset();
        step(-30000, "R11 warm");
        step(-30000, "R11 warm");
        step(0, "R11 negative clamp");
        chk($signed(out_y) == -32768, "R11 clamp low", int'($signed(out_y)), -32768);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_warmup();
        t_ramp_inject();
        t_threshold_edge();
        t_diff_mode();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule